// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is an on-chip synchronous static memory with a 32-bit word split into four byte lanes. Address, control and write data are captured on the rising clock edge. A read result passes through an output register, so it reaches the data port one clock after the access is taken. Accesses begin on either of two start strobes. The processor-side strobe is gated by the first chip enable. The controller-side strobe is not gated. After a start, a two-bit burst counter walks through the other three words of the aligned group of four, in linear or interleaved order. The counter steps only when the advance input is asserted.

Writes are selected per byte lane, or for all lanes at once through a global write input. Output enable and the sleep input gate the data port without waiting for a clock edge. While sleep is high the memory accepts no access and keeps its contents. After sleep is released, a fixed lockout of a few cycles follows. Any strobe that arrives during the lockout is dropped and reported on an error output.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held and on the first cycle after it, `dq_drive` and `lockout_err` are low and `rdata` is zero.
- R2: A low `ads_proc_n` is ignored while `ce1_n` is high. In that case a live burst continues as if no strobe had arrived, unless `ads_ctrl_n` is low.
- R3: `ce2` (active high) and `ce3_n` (active low) are sampled only on cycles that accept a strobe. If any enable is inactive on such a cycle, the block is deselected and `dq_drive` stays low until the next selecting start. Enable changes on cycles without a strobe have no effect.
- R4: A start through `ads_proc_n` is always a read, whatever the write inputs are. A write given on the next cycle with `adv_n` high goes to that same address.
- R5: With `gw_n` high and `bwe_n` low, each low bit of `bw_n[i]` writes lane i, which is data bits 8i+7 to 8i. The other lanes keep their old contents.
- R6: A low `gw_n` writes all four lanes. With `gw_n` high and either `bwe_n` high or all of `bw_n` high, the cycle is a read.
- R7: Data for an address taken at edge k appears on `rdata` after edge k+1. `dq_drive` is high only when that slot holds read data, `oe_n` is low and `sleep` is low. Otherwise `rdata` is zero.
- R8: After a start at address A, the low two address bits are A+n mod 4 when `burst_linear` is 1, and A XOR n when it is 0. Here n counts the cycles with `adv_n` low. A cycle with `adv_n` high accesses the current address again. The upper address bits never change during a burst.
- R9: While `sleep` is high, no access is taken and stored data is kept. For 2 cycles after `sleep` falls, every strobe is ignored.
- R10: A strobe during the post-sleep lockout raises `lockout_err` for the one cycle after that edge. Strobes during sleep itself do not raise it.
- R11: A read issued on the cycle after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| ads_proc_n | input | 1 | Processor start strobe, active low, masked by ce1_n |
| ads_ctrl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | DATA_W/8 | Per-lane write selects, active low |
| wdata | input | DATA_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| burst_linear | input | 1 | 1 selects linear burst order, 0 interleaved |
| rdata | output | DATA_W | Read data, zero when not driven |
| dq_drive | output | 1 | High when rdata carries valid read data |
| lockout_err | output | 1 | Strobe seen during post-sleep lockout |

## Verification
The bench builds the block with its defaults: a 6-bit address (64 words), a 32-bit word and a 2-cycle wake lockout. With only 64 words, random addresses hit the same word often. Random traffic therefore keeps producing reads right after writes, partial-lane overwrites of live data, and bursts that wrap inside their group of four. The short lockout lets random sleep episodes land strobes in both locked cycles as well as on the first free one.

// File: rtl/sram_pkg.sv
// Shared constants for the burst SRAM blocks.
// Assumes byte lanes of 8 bits and a 4-word burst group.
package sram_pkg;
    localparam int LANE_W  = 8;
    localparam int BURST_W = 2;
endpackage

// File: rtl/sram_burst_seq.sv
// Burst address sequencer: yields the low address bits for this edge.
// On load it passes start_lo through and clears the beat count. On step it
// advances the count. The order is linear (add) or interleaved (xor).
// Assumes load and step are never both high.
module sram_burst_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] start_lo,
    input  logic          linear,
    output logic [CW-1:0] eff_lo
);
    logic [CW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    // Next beat count and the address bits for this edge
    always_comb begin
        cnt_nx = step ? cnt_q + CW'(1) : cnt_q;
        if (load)
            eff_lo = start_lo;
        else if (linear)
            eff_lo = base_q + cnt_nx;
        else
            eff_lo = base_q ^ cnt_nx;
    end

    // Hold the burst base and beat count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= start_lo;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_nx;
        end
    end
endmodule

// File: rtl/sram_byte_dec.sv
// Write-lane decoder: global write selects every lane. Otherwise the
// byte-write qualifier enables the per-lane selects. force_read blanks all.
// Assumes all inputs are active low except force_read.
module sram_byte_dec #(
    parameter int NB = 4
) (
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          force_read,
    output logic [NB-1:0] mask
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        // One lane enable
        always_comb mask[g] = !force_read && (!gw_n || (!bwe_n && !bw_n[g]));
    end
endmodule

// File: rtl/sram_wake_guard.sv
// Sleep guard: locked while sleep is high and for LOCK_CYC cycles after it
// falls. It flags strobes that land in the post-sleep window.
// Assumes sleep is already stable by the sampling edge.
module sram_wake_guard #(
    parameter int LOCK_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic strobe_any,
    output logic locked,
    output logic err
);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);
    logic [CNT_W-1:0] lock_q;

    // Lock is active while asleep or while the counter runs
    always_comb locked = sleep || (lock_q != '0);

    // Reload while asleep, count down afterwards, flag late strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            err    <= 1'b0;
        end else begin
            err <= !sleep && (lock_q != '0) && strobe_any;
            if (sleep)
                lock_q <= CNT_W'(LOCK_CYC);
            else if (lock_q != '0)
                lock_q <= lock_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/sram_mem_array.sv
// Storage array with lane-masked writes and a registered read word.
// Assumes read and write are never requested on the same edge.
module sram_mem_array #(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [NB-1:0]      wmask,
    input  logic [NB*8-1:0]    wdata,
    output logic [NB*8-1:0]    rd_q
);
    import sram_pkg::*;
    localparam int DEPTH = 1 << AW;
    logic [NB*LANE_W-1:0] mem [DEPTH];

    // Lane-masked write
    always_ff @(posedge clk) begin
        if (wr_en)
            for (int b = 0; b < NB; b++)
                if (wmask[b])
                    mem[addr][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
    end

    // Output register, updated only by reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= mem[addr];
    end
endmodule

// File: rtl/sync_burst_sram.sv
// Pipelined synchronous burst SRAM. Stage 1 registers the decoded access
// (address, lane mask, write data). Stage 2 writes the array or loads the
// output register. The data port is gated by oe_n and sleep without a clock.
// Assumes ADDR_W > 2 and DATA_W a multiple of 8. burst_linear is held
// steady during bursts.
module sync_burst_sram #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int LOCK_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  ads_proc_n,
    input  logic                  ads_ctrl_n,
    input  logic                  adv_n,
    input  logic                  ce1_n,
    input  logic                  ce2,
    input  logic                  ce3_n,
    input  logic                  gw_n,
    input  logic                  bwe_n,
    input  logic [DATA_W/8-1:0]   bw_n,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  oe_n,
    input  logic                  sleep,
    input  logic                  burst_linear,
    output logic [DATA_W-1:0]     rdata,
    output logic                  dq_drive,
    output logic                  lockout_err
);
    import sram_pkg::*;
    localparam int NB   = DATA_W / LANE_W;
    localparam int HI_W = ADDR_W - BURST_W;

    logic              locked, strobe_any;
    logic              proc_go, ctrl_go, start, chips_ok;
    logic              live_q, cont, step, access;
    logic [BURST_W-1:0] eff_lo;
    logic [HI_W-1:0]   hi_q, hi_now;
    logic [NB-1:0]     wmask;
    logic              s1_rd, s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_wdata;
    logic [NB-1:0]     s1_mask;
    logic              out_vld;
    logic [DATA_W-1:0] rd_q;

    // Strobe arbitration and access decode for this edge
    always_comb begin
        strobe_any = !ads_proc_n || !ads_ctrl_n;
        proc_go    = !ads_proc_n && !ce1_n && !locked;
        ctrl_go    = !ads_ctrl_n && !proc_go && !locked;
        start      = proc_go || ctrl_go;
        chips_ok   = !ce1_n && ce2 && !ce3_n;
        cont       = !start && !locked && live_q;
        step       = cont && !adv_n;
        access     = start ? chips_ok : cont;
        hi_now     = start ? addr[ADDR_W-1:BURST_W] : hi_q;
    end

    sram_wake_guard #(.LOCK_CYC(LOCK_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .strobe_any(strobe_any),
        .locked(locked), .err(lockout_err)
    );

    sram_burst_seq #(.CW(BURST_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(start), .step(step),
        .start_lo(addr[BURST_W-1:0]), .linear(burst_linear), .eff_lo(eff_lo)
    );

    sram_byte_dec #(.NB(NB)) u_dec (
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .force_read(proc_go), .mask(wmask)
    );

    // Burst liveness and upper address, changed only by accepted starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            hi_q   <= '0;
        end else if (start) begin
            live_q <= chips_ok;
            hi_q   <= addr[ADDR_W-1:BURST_W];
        end
    end

    // Stage 1: register the decoded access together with its write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_rd    <= 1'b0;
            s1_wr    <= 1'b0;
            s1_addr  <= '0;
            s1_wdata <= '0;
            s1_mask  <= '0;
        end else begin
            s1_rd    <= access && (wmask == '0);
            s1_wr    <= access && (wmask != '0);
            s1_addr  <= {hi_now, eff_lo};
            s1_wdata <= wdata;
            s1_mask  <= wmask;
        end
    end

    sram_mem_array #(.AW(ADDR_W), .NB(NB)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(s1_wr), .rd_en(s1_rd),
        .addr(s1_addr), .wmask(s1_mask), .wdata(s1_wdata), .rd_q(rd_q)
    );

    // Stage 2: mark the output slot as holding read data
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= s1_rd;
    end

    // Asynchronous output gating
    always_comb begin
        dq_drive = out_vld && !oe_n && !sleep;
        rdata    = dq_drive ? rd_q : '0;
    end
endmodule

// File: rtl/sram_burst_checker.sv
// Protocol checker for sync_burst_sram, attached by bind.
// Assumes the internal names of the top module listed in the bind.
module sram_burst_checker #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          gw_n,
    input logic          ce2,
    input logic          proc_go,
    input logic          start,
    input logic          access,
    input logic          locked,
    input logic          live_q,
    input logic          s1_rd,
    input logic          s1_wr,
    input logic [NB-1:0] s1_mask,
    input logic          out_vld,
    input logic          lockout_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !lockout_err));

    assert_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ce2) |=> !live_q);

    assert_proc_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        proc_go |=> !s1_wr);

    assert_global_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !proc_go && !gw_n) |=> (s1_wr && (s1_mask == '1)));

    assert_pipe_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(s1_rd));

    assert_sleep_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !(s1_rd || s1_wr));

    assert_lock_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_err |-> $past(locked && !sleep));
endmodule

bind sync_burst_sram sram_burst_checker #(.NB(DATA_W/8)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .gw_n(gw_n), .ce2(ce2),
    .proc_go(proc_go), .start(start), .access(access), .locked(locked),
    .live_q(live_q), .s1_rd(s1_rd), .s1_wr(s1_wr), .s1_mask(s1_mask),
    .out_vld(out_vld), .lockout_err(lockout_err)
);

// File: tb/sync_burst_sram_test.sv
// Bench: directed corner cases, then seeded random traffic, checked against
// a cycle model built from the requirements.
module sync_burst_sram_test;
    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int DW    = 32;
    localparam int NB    = DW / 8;
    localparam int LOCKC = 2;

    logic clk = 0;
    always #(CLK_P/2) clk = ~clk;

    logic rst_n, ads_proc_n, ads_ctrl_n, adv_n, ce1_n, ce2, ce3_n;
    logic gw_n, bwe_n, oe_n, sleep, burst_linear;
    logic [NB-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic dq_drive, lockout_err;

    // staged inputs, applied at the next negative edge
    logic n_rst, n_adsp, n_adsc, n_adv, n_ce1, n_ce2, n_ce3, n_gw, n_bwe, n_oe, n_slp, n_lin;
    logic [NB-1:0] n_bw;
    logic [AW-1:0] n_addr;
    logic [DW-1:0] n_wd;

    int n_checks = 0, n_fail = 0;

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LOCK_CYC(LOCKC)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ads_proc_n(ads_proc_n),
        .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .burst_linear(burst_linear),
        .rdata(rdata), .dq_drive(dq_drive), .lockout_err(lockout_err)
    );

    // ---- reference model state ----
    logic [DW-1:0] m_mem [1<<AW];
    logic          m_live, m_s1rd, m_s1wr, m_vld, m_err;
    logic [1:0]    m_base, m_cnt;
    logic [AW-3:0] m_hi;
    logic [AW-1:0] m_s1a;
    logic [DW-1:0] m_s1d, m_out;
    logic [NB-1:0] m_s1m;
    int            m_lock;

    function automatic logic [1:0] burst_lo(logic [1:0] b, logic [1:0] c, logic lin);
        return lin ? b + c : b ^ c;
    endfunction

    function automatic logic [NB-1:0] lane_sel(logic pgo, logic g, logic be, logic [NB-1:0] bw);
        if (pgo) return '0;
        if (!g)  return '1;
        if (!be) return ~bw;
        return '0;
    endfunction

    // advance the model across one rising edge using the applied inputs
    task automatic model_step();
        logic lk, pgo, cgo, st, ok, acc;
        logic [AW-1:0] ea;
        logic [NB-1:0] mk;
        if (!rst_n) begin
            m_live = 0; m_s1rd = 0; m_s1wr = 0; m_vld = 0; m_err = 0;
            m_base = 0; m_cnt = 0; m_hi = 0; m_s1a = 0; m_s1d = 0; m_s1m = 0;
            m_out = 0; m_lock = 0;
            return;
        end
        if (m_s1wr)
            for (int b = 0; b < NB; b++)
                if (m_s1m[b]) m_mem[m_s1a][b*8 +: 8] = m_s1d[b*8 +: 8];
        if (m_s1rd) m_out = m_mem[m_s1a];
        m_vld = m_s1rd;
        lk  = sleep || (m_lock != 0);
        m_err = !sleep && (m_lock != 0) && (!ads_proc_n || !ads_ctrl_n);
        pgo = !ads_proc_n && !ce1_n && !lk;
        cgo = !ads_ctrl_n && !pgo && !lk;
        st  = pgo || cgo;
        ok  = !ce1_n && ce2 && !ce3_n;
        ea  = addr;
        acc = 0;
        if (st) begin
            m_live = ok; m_base = addr[1:0]; m_cnt = 0; m_hi = addr[AW-1:2];
            acc = ok;
        end else if (!lk && m_live) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            ea  = {m_hi, burst_lo(m_base, m_cnt, burst_linear)};
            acc = 1;
        end
        mk = lane_sel(pgo, gw_n, bwe_n, bw_n);
        m_s1rd = acc && (mk == 0);
        m_s1wr = acc && (mk != 0);
        m_s1a = ea; m_s1d = wdata; m_s1m = mk;
        if (sleep) m_lock = LOCKC;
        else if (m_lock != 0) m_lock = m_lock - 1;
    endtask

    task automatic check(string tag);
        logic ed;
        logic [DW-1:0] er;
        ed = m_vld && !oe_n && !sleep;
        er = ed ? m_out : '0;
        n_checks++;
        if (dq_drive !== ed || rdata !== er || lockout_err !== m_err) begin
            n_fail++;
            $display("FAIL %s: rdata=%h drive=%b err=%b expected rdata=%h drive=%b err=%b",
                     tag, rdata, dq_drive, lockout_err, er, ed, m_err);
        end
    endtask

    // check the outcome of the last edge, then apply the staged inputs
    task automatic tick(string tag);
        @(negedge clk);
        check(tag);
        rst_n = n_rst; ads_proc_n = n_adsp; ads_ctrl_n = n_adsc; adv_n = n_adv;
        ce1_n = n_ce1; ce2 = n_ce2; ce3_n = n_ce3; gw_n = n_gw; bwe_n = n_bwe;
        bw_n = n_bw; addr = n_addr; wdata = n_wd; oe_n = n_oe; sleep = n_slp;
        burst_linear = n_lin;
        model_step();
    endtask

    task automatic idle();
        n_rst = 1; n_adsp = 1; n_adsc = 1; n_adv = 1; n_ce1 = 0; n_ce2 = 1; n_ce3 = 0;
        n_gw = 1; n_bwe = 1; n_bw = '1; n_oe = 0; n_slp = 0;
    endtask

    task automatic ctrl_op(logic [AW-1:0] a, logic g, logic be, logic [NB-1:0] bw, logic [DW-1:0] d);
        idle(); n_adsc = 0; n_addr = a; n_gw = g; n_bwe = be; n_bw = bw; n_wd = d;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
        rst_n = 0; ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = '1; addr = '0; wdata = '0; oe_n = 0; sleep = 0;
        burst_linear = 1;
        idle(); n_rst = 0; n_addr = '0; n_wd = '0; n_lin = 1;
        model_step();
        tick("R1"); tick("R1");
        idle();
        tick("R1");

        // prefill every word with a global write (R6)
        for (int a = 0; a < (1<<AW); a++) begin
            ctrl_op(AW'(a), 0, 1, '1, 32'hA500_0000 | 32'(a * 32'h0101));
            tick("R6");
        end
        idle(); n_adsc = 0; n_ce2 = 0;   // deselect to end the burst (R3)
        tick("R6");
        idle(); tick("R3"); tick("R3"); tick("R3");

        // read right after a write to the same word (R11, R6 read decode)
        ctrl_op(5, 0, 1, '1, 32'hDEAD_BEEF); tick("R11");
        ctrl_op(5, 1, 1, 4'b0000, 32'h0);    tick("R11");
        idle(); n_adv = 1; tick("R11"); tick("R11"); tick("R7");

        // partial lane write (R5)
        ctrl_op(9, 1, 0, 4'b1010, 32'h1122_3344); tick("R5");
        ctrl_op(9, 1, 1, 4'b0000, 32'h0);          tick("R5");
        idle(); tick("R5"); tick("R5");

        // processor strobe masked by ce1_n (R2): burst at 9 keeps reading
        idle(); n_adsp = 0; n_ce1 = 1; n_addr = 12; tick("R2");
        idle(); tick("R2"); tick("R2");

        // enables without a strobe do nothing; with a strobe they deselect (R3)
        idle(); n_ce2 = 0; n_ce3 = 1; tick("R3");
        idle(); tick("R3"); tick("R3");
        idle(); n_adsc = 0; n_ce3 = 1; n_addr = 3; tick("R3");
        idle(); tick("R3"); tick("R3"); tick("R3");

        // processor start is a read, next-cycle write hits the same word (R4)
        idle(); n_adsp = 0; n_addr = 20; n_gw = 0; n_wd = 32'h0BAD_0BAD; tick("R4");
        idle(); n_gw = 0; n_wd = 32'hCAFE_F00D; tick("R4");
        ctrl_op(20, 1, 1, '1, 0); tick("R4");
        idle(); tick("R4"); tick("R4");

        // burst orders from base 5 (R8)
        for (int md = 0; md < 2; md++) begin
            n_lin = logic'(md);
            ctrl_op(5, 1, 1, '1, 0); n_lin = logic'(md); tick("R8");
            for (int k = 0; k < 5; k++) begin idle(); n_adv = 0; tick("R8"); end
            idle(); n_adv = 1; tick("R8"); tick("R8");
        end

        // sleep, retention, lockout and its flag (R9, R10)
        n_lin = 1;
        ctrl_op(33, 0, 1, '1, 32'h5151_5151); tick("R9");
        for (int k = 0; k < 3; k++) begin idle(); n_slp = 1; n_adsc = 0; n_addr = 7; tick("R9"); end
        idle(); n_adsc = 0; n_addr = 7; tick("R9");
        idle(); n_adsp = 0; n_addr = 8; tick("R10");
        idle(); tick("R10");
        ctrl_op(33, 1, 1, '1, 0); tick("R10");
        idle(); tick("R9"); tick("R9");

        // seeded random traffic in both burst orders (R7 and the rest)
        for (int md = 0; md < 2; md++) begin
            for (int c = 0; c < 1500; c++) begin
                n_rst  = 1;
                n_adsp = ($urandom_range(3) != 0);
                n_adsc = ($urandom_range(3) != 0);
                n_adv  = $urandom_range(1);
                n_ce1  = ($urandom_range(9) < 2);
                n_ce2  = ($urandom_range(9) != 0);
                n_ce3  = ($urandom_range(9) == 0);
                n_gw   = ($urandom_range(4) != 0);
                n_bwe  = $urandom_range(1);
                n_bw   = NB'($urandom);
                n_addr = AW'($urandom);
                n_wd   = $urandom;
                n_oe   = ($urandom_range(7) == 0);
                n_lin  = logic'(md);
                if (sleep) n_slp = ($urandom_range(9) > 2);
                else       n_slp = ($urandom_range(49) == 0);
                if (c > 1490) n_slp = 0;
                tick("R7");
            end
        end
        idle(); tick("R7"); tick("R7"); tick("R7");

        // reset while busy (R1)
        idle(); n_rst = 0; tick("R1");
        idle(); tick("R1"); tick("R1");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule